// File: doc/BRIEF.md
# Rotating Overlapped Register Window File

This block is the integer register file of a processor that passes procedure arguments through shared registers instead of through memory. It holds 74 physical 32-bit registers. Every procedure addresses 32 logical registers with 5-bit numbers. A 2-bit window pointer selects which slice of the physical storage those logical numbers reach. Ten global registers sit outside the rotating part and look the same from every window. The other 64 registers form a ring of four windows. Each window has ten private registers and two groups of six that it shares with its two neighbours.

A call strobe advances the window pointer by one, so the caller's upper shared group becomes the callee's lower shared group. Arguments and results therefore move between procedures with no copy. A return strobe moves the pointer back. The ring wraps from the last window to the first, and a one-cycle flag marks each wrap so that surrounding logic can decide whether a spill or fill is needed. Spill and fill are not part of this block.

Two read ports are combinational and use the current pointer. The single write port commits on the rising clock edge. It is addressed through the pointer value in force before any strobe in that same cycle takes effect.

Top module: `orw_file`

## Requirements
- R1: After reset the pointer `cwp` is 0, `wrap_pulse` is 0, and every register reads as 0 from every window.
- R2: Logical registers 0–9 reach physical registers 0–9 whatever the pointer value, so a global written in one window reads back unchanged in every other window.
- R3: In window w, logical register r in 10–31 reaches physical register 10 + ((r − 10 + 16·w) mod 64). Both read ports return the contents of that register combinationally, within the same cycle.
- R4: Logical registers 16–25 are private to their window. A write to them in window w is not visible through logical 16–25 of any other window.
- R5: A call strobe alone makes `cwp` = (cwp + 1) mod 4 at the next edge. A return strobe alone makes it (cwp − 1) mod 4. Both strobes together, or neither, leave it unchanged.
- R6: A write in the same cycle as a call or return lands in the register selected by the pointer value before the strobe. A write to logical 26–31 with a call therefore reads back as logical 10–15 of the new window.
- R7: `wrap_pulse` is 1 for exactly the cycle after an edge where a lone call moved `cwp` from 3 to 0 or a lone return moved it from 0 to 3. It is 0 in every other cycle.
- R8: The two read ports are independent. Each returns its own register in the same cycle, including when both name the same register or when a write to that register is pending at the next edge; in that case each port returns the old value.
- R9: The ring closes: logical 26–31 of window 3 and logical 10–15 of window 0 are the same physical registers 10–15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| call_stb | input | 1 | Advance the window pointer at the next edge |
| ret_stb | input | 1 | Retreat the window pointer at the next edge |
| rd_a_idx | input | 5 | Logical register number for read port A |
| rd_a_data | output | 32 | Contents of the register named by `rd_a_idx` |
| rd_b_idx | input | 5 | Logical register number for read port B |
| rd_b_data | output | 32 | Contents of the register named by `rd_b_idx` |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Logical register number to write |
| wr_data | input | 32 | Data to write |
| cwp | output | 2 | Current window pointer |
| wrap_pulse | output | 1 | One-cycle flag for a pointer wrap in either direction |

## Verification
A write and a pointer move can fall in the same cycle. This is the case that decides whether an argument ends up in the caller's outgoing group or lands one window off. The random stimulus issues calls and returns in about half of all cycles, with writes in most of them, so the two coincide often. Directed cases force a write to the outgoing group together with a call, both at an inner window and across the 3-to-0 wrap. Each case is judged by reading the callee's incoming group through both ports in the next cycle. The result is compared against a bench model that updates its storage with the pointer value from before the edge.

// File: rtl/orw_pkg.sv
package orw_pkg;

  // Map a logical register number to a physical one for a given window.
  // Globals sit below n_glob; the rest form a ring of (n_loc+n_shr)*n_win.
  function automatic int log_to_phys(input int lidx, input int win,
                                     input int n_glob, input int n_loc,
                                     input int n_shr, input int n_win);
    int ring;
    int off;
    ring = (n_loc + n_shr) * n_win;
    if (lidx < n_glob) begin
      return lidx;
    end
    off = (lidx - n_glob) + (n_loc + n_shr) * win;
    if (off >= ring) begin
      off = off - ring;
    end
    return n_glob + off;
  endfunction

  // Next pointer value for one step up or down a ring of n_win windows.
  function automatic int ptr_step(input int cur, input bit up, input int n_win);
    if (up) begin
      return (cur == n_win - 1) ? 0 : cur + 1;
    end
    return (cur == 0) ? n_win - 1 : cur - 1;
  endfunction

endpackage

// File: rtl/orw_window_ptr.sv
module orw_window_ptr #(
  parameter int N_WIN = 4,
  parameter int CWP_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             call_stb,
  input  logic             ret_stb,
  output logic [CWP_W-1:0] cwp_q,
  output logic             wrap_q
);
  localparam logic [CWP_W-1:0] TOP_WIN = CWP_W'(N_WIN - 1);

  logic             call_only;
  logic             ret_only;
  logic [CWP_W-1:0] cwp_nx;
  logic             wrap_nx;

  assign call_only = call_stb & ~ret_stb;
  assign ret_only  = ret_stb & ~call_stb;

  always_comb begin
    cwp_nx  = cwp_q;
    wrap_nx = 1'b0;
    if (call_only) begin
      cwp_nx  = CWP_W'(orw_pkg::ptr_step(int'(cwp_q), 1'b1, N_WIN));
      wrap_nx = (cwp_q == TOP_WIN);
    end else if (ret_only) begin
      cwp_nx  = CWP_W'(orw_pkg::ptr_step(int'(cwp_q), 1'b0, N_WIN));
      wrap_nx = (cwp_q == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      cwp_q  <= cwp_nx;
      wrap_q <= wrap_nx;
    end
  end
endmodule

// File: rtl/orw_addr_map.sv
module orw_addr_map #(
  parameter int N_GLOB = 10,
  parameter int N_LOC  = 10,
  parameter int N_SHR  = 6,
  parameter int N_WIN  = 4,
  parameter int LIDX_W = 5,
  parameter int PIDX_W = 7,
  parameter int CWP_W  = 2
) (
  input  logic [LIDX_W-1:0] lidx,
  input  logic [CWP_W-1:0]  win,
  output logic [PIDX_W-1:0] pidx
);
  always_comb begin
    pidx = PIDX_W'(orw_pkg::log_to_phys(int'(lidx), int'(win),
                                        N_GLOB, N_LOC, N_SHR, N_WIN));
  end
endmodule

// File: rtl/orw_regfile.sv
module orw_regfile #(
  parameter int DATA_W = 32,
  parameter int N_PHYS = 74,
  parameter int PIDX_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PIDX_W-1:0] wr_pidx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PIDX_W-1:0] rd_a_pidx,
  input  logic [PIDX_W-1:0] rd_b_pidx,
  output logic [DATA_W-1:0] rd_a_data,
  output logic [DATA_W-1:0] rd_b_data
);
  localparam logic [PIDX_W-1:0] LAST_P = PIDX_W'(N_PHYS - 1);

  logic [DATA_W-1:0] mem [N_PHYS];

  for (genvar p = 0; p < N_PHYS; p++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_pidx == PIDX_W'(p));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[p] <= '0;
      end else if (hit) begin
        mem[p] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_a_data = (rd_a_pidx <= LAST_P) ? mem[rd_a_pidx] : '0;
    rd_b_data = (rd_b_pidx <= LAST_P) ? mem[rd_b_pidx] : '0;
  end
endmodule

// File: rtl/orw_file.sv
module orw_file #(
  parameter int DATA_W = 32,
  parameter int N_GLOB = 10,
  parameter int N_LOC  = 10,
  parameter int N_SHR  = 6,
  parameter int N_WIN  = 4,
  parameter int LIDX_W = $clog2(N_GLOB + N_LOC + 2 * N_SHR),
  parameter int CWP_W  = $clog2(N_WIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_stb,
  input  logic              ret_stb,
  input  logic [LIDX_W-1:0] rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [LIDX_W-1:0] rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [LIDX_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CWP_W-1:0]  cwp,
  output logic              wrap_pulse
);
  localparam int N_PHYS = (N_LOC + N_SHR) * N_WIN + N_GLOB;
  localparam int PIDX_W = $clog2(N_PHYS);
  localparam int N_MAP  = 3;

  // Named internal events for the checker.
  logic [CWP_W-1:0]  cwp_q;
  logic              wrap_q;
  logic [PIDX_W-1:0] rd_a_phys;
  logic [PIDX_W-1:0] rd_b_phys;
  logic [PIDX_W-1:0] wr_phys;

  logic [LIDX_W-1:0] map_in  [N_MAP];
  logic [PIDX_W-1:0] map_out [N_MAP];

  orw_window_ptr #(
    .N_WIN (N_WIN),
    .CWP_W (CWP_W)
  ) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .call_stb (call_stb),
    .ret_stb  (ret_stb),
    .cwp_q    (cwp_q),
    .wrap_q   (wrap_q)
  );

  assign map_in[0] = rd_a_idx;
  assign map_in[1] = rd_b_idx;
  assign map_in[2] = wr_idx;

  for (genvar k = 0; k < N_MAP; k++) begin : g_map
    orw_addr_map #(
      .N_GLOB (N_GLOB),
      .N_LOC  (N_LOC),
      .N_SHR  (N_SHR),
      .N_WIN  (N_WIN),
      .LIDX_W (LIDX_W),
      .PIDX_W (PIDX_W),
      .CWP_W  (CWP_W)
    ) u_map (
      .lidx (map_in[k]),
      .win  (cwp_q),
      .pidx (map_out[k])
    );
  end

  assign rd_a_phys = map_out[0];
  assign rd_b_phys = map_out[1];
  assign wr_phys   = map_out[2];

  orw_regfile #(
    .DATA_W (DATA_W),
    .N_PHYS (N_PHYS),
    .PIDX_W (PIDX_W)
  ) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_pidx   (wr_phys),
    .wr_data   (wr_data),
    .rd_a_pidx (rd_a_phys),
    .rd_b_pidx (rd_b_phys),
    .rd_a_data (rd_a_data),
    .rd_b_data (rd_b_data)
  );

  assign cwp        = cwp_q;
  assign wrap_pulse = wrap_q;
endmodule

// File: rtl/orw_file_chk.sv
module orw_file_chk #(
  parameter int N_GLOB = 10,
  parameter int N_WIN  = 4,
  parameter int LIDX_W = 5,
  parameter int PIDX_W = 7,
  parameter int CWP_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              call_stb,
  input logic              ret_stb,
  input logic [LIDX_W-1:0] rd_a_idx,
  input logic [PIDX_W-1:0] rd_a_phys,
  input logic [CWP_W-1:0]  cwp,
  input logic              wrap_pulse
);
  localparam logic [CWP_W-1:0] TOP_WIN = CWP_W'(N_WIN - 1);

  a_r5_call_step: assert property (@(posedge clk) disable iff (!rst_n)
    (call_stb && !ret_stb) |=> (cwp == (($past(cwp) == TOP_WIN) ? '0 : $past(cwp) + 1'b1)));

  a_r5_ret_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_stb && !call_stb) |=> (cwp == (($past(cwp) == '0) ? TOP_WIN : $past(cwp) - 1'b1)));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (call_stb == ret_stb) |=> $stable(cwp));

  a_r7_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
    (call_stb && !ret_stb && cwp == TOP_WIN) |=> wrap_pulse);

  a_r7_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_stb && !call_stb && cwp == '0) |=> wrap_pulse);

  a_r7_no_idle_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (call_stb == ret_stb) |=> !wrap_pulse);

  a_r2_global_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_a_idx) < N_GLOB) |-> (int'(rd_a_phys) == int'(rd_a_idx)));
endmodule

bind orw_file orw_file_chk #(
  .N_GLOB (N_GLOB),
  .N_WIN  (N_WIN),
  .LIDX_W (LIDX_W),
  .PIDX_W (PIDX_W),
  .CWP_W  (CWP_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .call_stb   (call_stb),
  .ret_stb    (ret_stb),
  .rd_a_idx   (rd_a_idx),
  .rd_a_phys  (rd_a_phys),
  .cwp        (cwp),
  .wrap_pulse (wrap_pulse)
);

// File: tb/test_orw_file.sv
module test_orw_file;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        call_stb = 1'b0;
  logic        ret_stb = 1'b0;
  logic [4:0]  rd_a_idx = '0;
  logic [4:0]  rd_b_idx = '0;
  logic [31:0] rd_a_data;
  logic [31:0] rd_b_data;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  cwp;
  logic        wrap_pulse;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] model [74];
  int mcwp = 0;

  always #2 clk = ~clk;

  orw_file i_orw_file (
    .clk        (clk),
    .rst_n      (rst_n),
    .call_stb   (call_stb),
    .ret_stb    (ret_stb),
    .rd_a_idx   (rd_a_idx),
    .rd_a_data  (rd_a_data),
    .rd_b_idx   (rd_b_idx),
    .rd_b_data  (rd_b_data),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .cwp        (cwp),
    .wrap_pulse (wrap_pulse)
  );

  // Window w starts its ring slice at 10 + 16*w; slices beyond 73 fold back.
  function automatic int where(input int r, input int w);
    int p;
    if (r < 10) return r;
    p = 10 + 16 * w + (r - 10);
    while (p > 73) p = p - 64;
    return p;
  endfunction

  task automatic check(input string req, input string what,
                       input longint actual, input longint expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, actual, expected);
    end
  endtask

  // One clock: drive at negedge, check reads before the edge,
  // update the model at the edge, check pointer and flag after it.
  task automatic cycle(input bit c, input bit r, input bit we,
                       input int widx, input logic [31:0] wd,
                       input int ra, input int rb, input string rtag);
    int nc;
    bit exp_wrap;
    @(negedge clk);
    call_stb = c;
    ret_stb  = r;
    wr_en    = we;
    wr_idx   = 5'(widx);
    wr_data  = wd;
    rd_a_idx = 5'(ra);
    rd_b_idx = 5'(rb);
    #1;
    check(rtag, "port A read", rd_a_data, model[where(ra, mcwp)]);
    check(rtag, "port B read R8", rd_b_data, model[where(rb, mcwp)]);
    @(posedge clk);
    if (we) model[where(widx, mcwp)] = wd;
    nc = mcwp;
    exp_wrap = 1'b0;
    if (c && !r) begin
      nc = (mcwp + 1) % 4;
      exp_wrap = (mcwp == 3);
    end else if (r && !c) begin
      nc = (mcwp + 3) % 4;
      exp_wrap = (mcwp == 0);
    end
    mcwp = nc;
    #1;
    check("R5", "window pointer", cwp, mcwp);
    check("R7", "wrap flag", wrap_pulse, exp_wrap);
  endtask

  task automatic move_to(input int w);
    while (mcwp != w) cycle(1'b1, 1'b0, 1'b0, 0, '0, 0, 10, "R3");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0AB5_1D7E));
    for (int i = 0; i < 74; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check("R1", "pointer after reset", cwp, 0);
    check("R1", "wrap after reset", wrap_pulse, 0);
    for (int w = 0; w < 4; w++) begin
      for (int r = 0; r < 32; r += 2) cycle(1'b0, 1'b0, 1'b0, 0, '0, r, r + 1, "R1");
      cycle(1'b1, 1'b0, 1'b0, 0, '0, 0, 0, "R1");
    end

    // R2: global written in window 0, read in window 2
    move_to(0);
    cycle(1'b0, 1'b0, 1'b1, 7, 32'hC0DE_0007, 0, 0, "R2");
    move_to(2);
    cycle(1'b0, 1'b0, 1'b0, 0, '0, 7, 7, "R2");
    check("R2", "global direct", rd_a_data, 32'hC0DE_0007);

    // R4: private local in window 2 not seen from window 3
    cycle(1'b0, 1'b0, 1'b1, 20, 32'h1111_2020, 20, 20, "R4");
    cycle(1'b1, 1'b0, 1'b0, 0, '0, 20, 20, "R4");
    cycle(1'b0, 1'b0, 1'b0, 0, '0, 20, 21, "R4");
    check("R4", "other window local", rd_a_data, 32'h0);

    // R6: write to outgoing group together with a call, window 0 -> 1
    move_to(0);
    cycle(1'b1, 1'b0, 1'b1, 27, 32'hA6A6_0027, 0, 0, "R6");
    cycle(1'b0, 1'b0, 1'b0, 0, '0, 11, 27, "R6");
    check("R6", "arg seen by callee", rd_a_data, 32'hA6A6_0027);

    // R9 and R6: window 3 outgoing group with a call across the wrap
    move_to(3);
    cycle(1'b1, 1'b0, 1'b1, 31, 32'h9999_3031, 0, 0, "R9");
    cycle(1'b0, 1'b0, 1'b0, 0, '0, 15, 31, "R9");
    check("R9", "ring closes", rd_a_data, 32'h9999_3031);

    // R7: return from 0 wraps to 3; both strobes hold (R5)
    cycle(1'b0, 1'b1, 1'b1, 12, 32'h7777_0012, 12, 12, "R7");
    cycle(1'b1, 1'b1, 1'b0, 0, '0, 28, 12, "R5");
    check("R5", "both strobes hold", cwp, 3);

    // R8: same register on both ports while it is being written
    cycle(1'b0, 1'b0, 1'b1, 28, 32'h8888_0028, 28, 28, "R8");
    cycle(1'b0, 1'b0, 1'b0, 0, '0, 28, 28, "R8");

    // R3: constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      int sel;
      bit c;
      bit r;
      bit we;
      sel = int'($urandom_range(0, 7));
      c = (sel == 0) || (sel == 1) || (sel == 6);
      r = (sel == 2) || (sel == 3) || (sel == 6);
      we = ($urandom_range(0, 9) < 7);
      cycle(c, r, we, int'($urandom_range(0, 31)), $urandom(),
            int'($urandom_range(0, 31)), int'($urandom_range(0, 31)), "R3");
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule